// File: doc/BRIEF.md
# Multi-ring free-descriptor flow-control monitor

This block watches up to eight receive descriptor rings and raises a link-layer pause request when any ring that is marked active is running out of free descriptors. Each ring has its own registers:

- a threshold/length parameter word;
- a base pointer;
- a consume pointer, which the receive hardware moves one descriptor forward per strobe;
- a last-free pointer, which software moves as it hands buffers back.

The free count of a ring is the byte distance from the consume pointer forward to the last-free pointer, taken modulo the ring size in bytes and divided by the 8-byte descriptor size. Equal pointers mean that no descriptor is free.

A three-state sequencer owns the pause output. The states are:

- `PS_OFF`: monitoring is disabled.
- `PS_FLOW`: normal traffic.
- `PS_HOLD`: pause requested.

The transitions are:

- `EN_ON`: `PS_OFF` moves to `PS_FLOW` or `PS_HOLD` when the enable is seen.
- `SHORTAGE`: `PS_FLOW` moves to `PS_HOLD` when any active ring is short.
- `RECOVER`: `PS_HOLD` moves to `PS_FLOW` when no active ring is short.
- `EN_OFF`: any state moves to `PS_OFF` when the enable is clear.

Software programs the parameter words while the global enable is low. While the enable is high, the parameter words are locked. A write to a locked parameter word has no effect and raises a one-cycle error flag.

Top module: `rxring_pause_mon`

## Requirements
- R1: After reset, `pause_req` and `param_wr_err` are 0 and every parameter word is zero, so a threshold of 0 never requests a pause even with all rings active and enabled.
- R2: While `lfc_en` is 0, `pause_req` is 0 at the next clock edge, whatever the ring state.
- R3: A base-pointer write (`wr_kind` = 2'b01) loads that ring's base, consume and last-free pointers with the written value, so the ring has zero free descriptors.
- R4: A parameter write (`wr_kind` = 2'b00) stores the threshold from `wr_data[31:24]` and the ring length in descriptors from `wr_data[23:0]`. The free count is ((last_free − consume) mod (length×8)) / 8, including the case where last_free is numerically below consume.
- R5: A pause is requested when the free count of any active ring is strictly below that ring's threshold.
- R6: A pause is released only when every active ring has a free count greater than or equal to its threshold; a count equal to the threshold does not pause.
- R7: Rings whose `ring_active` bit is 0 never affect `pause_req`.
- R8: A pulse on `adv[i]` moves ring i's consume pointer 8 bytes forward. From the last descriptor (base + (length−1)×8), it wraps back to the base, over any number of laps.
- R9: A parameter write while `lfc_en` is 1 leaves the stored word unchanged. It sets `param_wr_err` for exactly the cycle after the write; pointer writes never set the flag.
- R10: `pause_req` reflects a register update one clock after that update: a write sampled at edge N changes `pause_req` at edge N+1.
- R11: Only the low 28 bits of pointer writes (`wr_kind` 2'b01 base, 2'b10 last-free) are used; bits 31:28 are ignored. Kind 2'b11 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lfc_en | input | 1 | Global enable for monitoring and parameter lock |
| ring_active | input | 8 | One bit per ring; 1 means the ring takes part in the pause decision |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 00 parameter word, 01 base pointer, 10 last-free pointer, 11 none |
| wr_ring | input | 3 | Ring index of the write |
| wr_data | input | 32 | Write data |
| adv | input | 8 | Consume-advance strobe per ring |
| pause_req | output | 1 | Registered link-layer pause request |
| param_wr_err | output | 1 | One-cycle flag for a write to a locked parameter word |

## Verification
Free counts are set at exactly threshold−1 and at exactly the threshold, which separates a strict compare from a non-strict one. Last-free values are placed both above and below a consume pointer that has been advanced part way round, which shows whether the modulo branch adds the ring size. A run of 32 advances on a 16-entry ring, followed by single steps across the last descriptor, shows whether the consume pointer wraps or runs off the end of the ring. Toggling the active mask while only an inactive ring is short, and writing pointers with junk in bits 31:28, show whether inactive rings and high address bits are kept out of the pause decision.

// File: rtl/rxpm_pkg.sv
package rxpm_pkg;

    // Kind of register addressed by a write.
    typedef enum logic [1:0] {
        WK_PARAM    = 2'b00,
        WK_BASE     = 2'b01,
        WK_LASTFREE = 2'b10,
        WK_NONE     = 2'b11
    } wr_kind_e;

    // States of the pause sequencer.
    typedef enum logic [1:0] {
        PS_OFF  = 2'b00,
        PS_FLOW = 2'b01,
        PS_HOLD = 2'b10
    } pause_state_e;

endpackage

// File: rtl/rxpm_wr_decode.sv
module rxpm_wr_decode
    import rxpm_pkg::*;
#(
    parameter int NUM_RINGS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_ring,
    input  logic [1:0]           wr_kind,
    input  logic                 lfc_en,
    output logic [NUM_RINGS-1:0] param_we,
    output logic [NUM_RINGS-1:0] base_we,
    output logic [NUM_RINGS-1:0] lastfree_we,
    output logic                 lock_err_o
);

    wr_kind_e kind;
    assign kind = wr_kind_e'(wr_kind);

    // Per-ring write enables; parameter words are locked while enabled.
    always_comb begin
        for (int i = 0; i < NUM_RINGS; i++) begin
            logic hit;
            hit            = wr_en && (wr_ring == IDX_W'(i));
            param_we[i]    = hit && (kind == WK_PARAM) && !lfc_en;
            base_we[i]     = hit && (kind == WK_BASE);
            lastfree_we[i] = hit && (kind == WK_LASTFREE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_err_o <= 1'b0;
        end else begin
            lock_err_o <= wr_en && (kind == WK_PARAM) && lfc_en;
        end
    end

endmodule

// File: rtl/rxpm_ring_slot.sv
module rxpm_ring_slot #(
    parameter int PTR_W      = 28,
    parameter int THR_W      = 8,
    parameter int LEN_W      = 24,
    parameter int DESC_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             param_we,
    input  logic             base_we,
    input  logic             lastfree_we,
    input  logic             adv,
    input  logic [THR_W-1:0] thr_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic [PTR_W-1:0] ptr_in,
    output logic             short_o
);

    localparam logic [PTR_W-1:0] DESC_BYTES = PTR_W'(1) << DESC_SHIFT;

    logic [THR_W-1:0] thr_q;
    logic [LEN_W-1:0] len_q;
    logic [PTR_W-1:0] base_q;
    logic [PTR_W-1:0] cons_q;
    logic [PTR_W-1:0] lf_q;

    logic [PTR_W-1:0] ring_bytes;
    logic [PTR_W-1:0] last_desc;
    logic [PTR_W-1:0] span;
    logic [PTR_W-1:0] thr_bytes;

    // Geometry and free space, all in bytes.
    always_comb begin
        ring_bytes = PTR_W'(len_q) << DESC_SHIFT;
        last_desc  = base_q + ring_bytes - DESC_BYTES;
        span       = lf_q - cons_q;
        if (lf_q < cons_q) begin
            span = span + ring_bytes;
        end
        thr_bytes  = PTR_W'(thr_q) << DESC_SHIFT;
        // free/8 < thr  <=>  free_bytes < thr*8
        short_o    = span < thr_bytes;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
            len_q <= '0;
        end else if (param_we) begin
            thr_q <= thr_in;
            len_q <= len_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cons_q <= '0;
            lf_q   <= '0;
        end else if (base_we) begin
            base_q <= ptr_in;
            cons_q <= ptr_in;
            lf_q   <= ptr_in;
        end else begin
            if (adv) begin
                cons_q <= (cons_q == last_desc) ? base_q : cons_q + DESC_BYTES;
            end
            if (lastfree_we) begin
                lf_q <= ptr_in;
            end
        end
    end

endmodule

// File: rtl/rxpm_pause_fsm.sv
module rxpm_pause_fsm
    import rxpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic any_short,
    output logic pause_o
);

    pause_state_e state_q;
    pause_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF: begin
                if (enable) begin                       // EN_ON
                    state_d = any_short ? PS_HOLD : PS_FLOW;
                end
            end
            PS_FLOW: begin
                if (!enable) begin
                    state_d = PS_OFF;                   // EN_OFF
                end else if (any_short) begin
                    state_d = PS_HOLD;                  // SHORTAGE
                end
            end
            PS_HOLD: begin
                if (!enable) begin
                    state_d = PS_OFF;                   // EN_OFF
                end else if (!any_short) begin
                    state_d = PS_FLOW;                  // RECOVER
                end
            end
            default: state_d = PS_OFF;
        endcase
    end

    always_comb begin
        pause_o = (state_q == PS_HOLD);
    end

endmodule

// File: rtl/rxring_pause_mon.sv
module rxring_pause_mon #(
    parameter int NUM_RINGS  = 8,
    parameter int PTR_W      = 28,
    parameter int THR_W      = 8,
    parameter int LEN_W      = 24,
    parameter int DESC_SHIFT = 3,
    localparam int IDX_W     = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1,
    localparam int DATA_W    = THR_W + LEN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lfc_en,
    input  logic [NUM_RINGS-1:0] ring_active,
    input  logic                 wr_en,
    input  logic [1:0]           wr_kind,
    input  logic [IDX_W-1:0]     wr_ring,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [NUM_RINGS-1:0] adv,
    output logic                 pause_req,
    output logic                 param_wr_err
);

    logic [NUM_RINGS-1:0] param_we;
    logic [NUM_RINGS-1:0] base_we;
    logic [NUM_RINGS-1:0] lastfree_we;
    logic [NUM_RINGS-1:0] short_vec;
    logic                 any_short;

    logic [THR_W-1:0] thr_field;
    logic [LEN_W-1:0] len_field;
    logic [PTR_W-1:0] ptr_field;

    // Threshold in the top byte, length below it; pointers use low bits only.
    assign thr_field = wr_data[DATA_W-1 -: THR_W];
    assign len_field = wr_data[LEN_W-1:0];
    assign ptr_field = wr_data[PTR_W-1:0];

    rxpm_wr_decode #(
        .NUM_RINGS (NUM_RINGS),
        .IDX_W     (IDX_W)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_ring     (wr_ring),
        .wr_kind     (wr_kind),
        .lfc_en      (lfc_en),
        .param_we    (param_we),
        .base_we     (base_we),
        .lastfree_we (lastfree_we),
        .lock_err_o  (param_wr_err)
    );

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        rxpm_ring_slot #(
            .PTR_W      (PTR_W),
            .THR_W      (THR_W),
            .LEN_W      (LEN_W),
            .DESC_SHIFT (DESC_SHIFT)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .param_we    (param_we[g]),
            .base_we     (base_we[g]),
            .lastfree_we (lastfree_we[g]),
            .adv         (adv[g]),
            .thr_in      (thr_field),
            .len_in      (len_field),
            .ptr_in      (ptr_field),
            .short_o     (short_vec[g])
        );
    end

    assign any_short = |(short_vec & ring_active);

    rxpm_pause_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (lfc_en),
        .any_short (any_short),
        .pause_o   (pause_req)
    );

endmodule

// File: rtl/rxpm_chk.sv
module rxpm_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lfc_en,
    input logic [N-1:0] ring_active,
    input logic         wr_en,
    input logic [1:0]   wr_kind,
    input logic [N-1:0] short_vec,
    input logic         pause_req,
    input logic         param_wr_err
);

    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lfc_en |=> !pause_req);

    p_assert_on_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lfc_en && |(short_vec & ring_active)) |=> pause_req);

    p_release_all_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lfc_en && ((short_vec & ring_active) == '0)) |=> !pause_req);

    p_idle_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_active == '0) |=> !pause_req);

    p_lock_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == 2'b00 && lfc_en) |=> param_wr_err);

    p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        param_wr_err |-> $past(wr_en && wr_kind == 2'b00 && lfc_en));

endmodule

bind rxring_pause_mon rxpm_chk #(.N(NUM_RINGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lfc_en       (lfc_en),
    .ring_active  (ring_active),
    .wr_en        (wr_en),
    .wr_kind      (wr_kind),
    .short_vec    (short_vec),
    .pause_req    (pause_req),
    .param_wr_err (param_wr_err)
);

// File: tb/sim_rxring_pause_mon.sv
module sim_rxring_pause_mon;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lfc_en = 1'b0;
    logic [7:0]  ring_active = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'b11;
    logic [2:0]  wr_ring = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  adv = '0;
    logic        pause_req;
    logic        param_wr_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rxring_pause_mon u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .lfc_en       (lfc_en),
        .ring_active  (ring_active),
        .wr_en        (wr_en),
        .wr_kind      (wr_kind),
        .wr_ring      (wr_ring),
        .wr_data      (wr_data),
        .adv          (adv),
        .pause_req    (pause_req),
        .param_wr_err (param_wr_err)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Issued at a negedge; returns at the negedge after the sampling edge.
    task automatic reg_wr(input logic [1:0] k, input int r, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_kind = k;
        wr_ring = 3'(r);
        wr_data = d;
        step();
        wr_en   = 1'b0;
        wr_kind = 2'b11;
    endtask

    task automatic advance(input int r, input int n);
        for (int i = 0; i < n; i++) begin
            adv[r] = 1'b1;
            step();
            adv[r] = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        chk(pause_req, 1'b0, "R1 pause after reset");
        chk(param_wr_err, 1'b0, "R1 err after reset");
        ring_active = 8'hFF;
        lfc_en = 1'b1;
        step(); step();
        chk(pause_req, 1'b0, "R1 zero thresholds never pause");
        lfc_en = 1'b0;
        step(); step();
    endtask

    task automatic t_disabled_quiet();
        reg_wr(2'b00, 0, {8'd4, 24'd16});
        reg_wr(2'b01, 0, 32'h0000_1000);
        reg_wr(2'b00, 1, {8'd2, 24'd8});
        reg_wr(2'b01, 1, 32'h0000_2000);
        reg_wr(2'b10, 1, 32'h0000_2010);
        chk(param_wr_err, 1'b0, "R9 no flag while disabled");
        ring_active = 8'h01;
        step(); step();
        chk(pause_req, 1'b0, "R2 disabled keeps pause low");
        lfc_en = 1'b1;
        step();
        chk(pause_req, 1'b1, "R3 empty ring after base write is short (R5)");
    endtask

    task automatic t_threshold_edges();
        reg_wr(2'b10, 0, 32'h0000_1018);
        step();
        chk(pause_req, 1'b1, "R5 free 3 below threshold 4");
        reg_wr(2'b10, 0, 32'h0000_1020);
        chk(pause_req, 1'b1, "R10 no change at the update edge");
        step();
        chk(pause_req, 1'b0, "R6 free equal to threshold releases (R10)");
    endtask

    task automatic t_modulo_wrap();
        reg_wr(2'b01, 0, 32'h0000_1000);
        step();
        chk(pause_req, 1'b1, "R3 base rewrite empties ring");
        advance(0, 13);                     // consume = 0x1068
        reg_wr(2'b10, 0, 32'h0000_1000);    // (0x00-0x68) mod 0x80 = 0x18 -> 3
        step();
        chk(pause_req, 1'b1, "R4 wrapped free count 3");
        reg_wr(2'b10, 0, 32'h0000_1008);    // 4 free
        step();
        chk(pause_req, 1'b0, "R4 wrapped free count 4");
        reg_wr(2'b10, 0, 32'h0000_1070);    // 1 free
        step();
        chk(pause_req, 1'b1, "R4 forward free count 1");
    endtask

    task automatic t_consume_wrap();
        reg_wr(2'b01, 0, 32'h0000_1000);
        reg_wr(2'b10, 0, 32'h0000_1018);    // 3 free
        advance(0, 32);                     // two laps -> back at base
        step();
        chk(pause_req, 1'b1, "R8 two laps return to base");
        reg_wr(2'b10, 0, 32'h0000_1020);    // 4 free
        step();
        chk(pause_req, 1'b0, "R8 four free after laps");
        advance(0, 15);                     // consume = 0x1078, 5 free
        step();
        chk(pause_req, 1'b0, "R8 at last descriptor");
        advance(0, 1);                      // wraps to 0x1000, 4 free
        step();
        chk(pause_req, 1'b0, "R8 wrap to base");
        advance(0, 1);                      // 0x1008, 3 free
        step();
        chk(pause_req, 1'b1, "R8 step after wrap");
        reg_wr(2'b10, 0, 32'h0000_1030);    // 5 free
        step();
        chk(pause_req, 1'b0, "R6 ring0 recovered");
    endtask

    task automatic t_inactive_mask();
        reg_wr(2'b01, 1, 32'h0000_2000);    // ring1 empty, threshold 2
        step();
        chk(pause_req, 1'b0, "R7 short inactive ring ignored");
        ring_active = 8'h03;
        step();
        chk(pause_req, 1'b1, "R7 ring1 now active and short");
        chk(pause_req, 1'b1, "R6 one short ring holds pause");
        ring_active = 8'h01;
        step();
        chk(pause_req, 1'b0, "R7 deactivated ring released");
        ring_active = 8'h03;
        reg_wr(2'b10, 1, 32'h0000_2010);    // ring1 2 free
        step();
        chk(pause_req, 1'b0, "R6 all active rings satisfied");
        ring_active = 8'h01;
        step();
    endtask

    task automatic t_locked_param();
        reg_wr(2'b10, 0, 32'h0000_1020);    // consume 0x1008 -> 3 free
        step();
        chk(pause_req, 1'b1, "R5 setup short");
        reg_wr(2'b00, 0, {8'd0, 24'd16});
        chk(param_wr_err, 1'b1, "R9 flag after locked write");
        step();
        chk(param_wr_err, 1'b0, "R9 flag lasts one cycle");
        chk(pause_req, 1'b1, "R9 threshold unchanged by locked write");
        reg_wr(2'b10, 0, 32'h0000_1020);
        chk(param_wr_err, 1'b0, "R9 pointer write raises no flag");
        reg_wr(2'b11, 0, 32'h0000_1000);
        step();
        chk(pause_req, 1'b1, "R11 kind 11 writes nothing");
    endtask

    task automatic t_high_bits();
        reg_wr(2'b01, 0, 32'hA000_1000);
        reg_wr(2'b10, 0, 32'h5000_1020);    // 4 free
        step();
        chk(pause_req, 1'b0, "R11 high bits ignored, 4 free");
        reg_wr(2'b10, 0, 32'h5000_1018);    // 3 free
        step();
        chk(pause_req, 1'b1, "R11 high bits ignored, 3 free");
    endtask

    task automatic t_disable_release();
        lfc_en = 1'b0;
        step();
        chk(pause_req, 1'b0, "R2 disable drops pause");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        t_reset_state();
        t_disabled_quiet();
        t_threshold_edges();
        t_modulo_wrap();
        t_consume_wrap();
        t_inactive_mask();
        t_locked_param();
        t_high_bits();
        t_disable_release();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hang expected finish");
            summary();
            $finish;
        end
    end

endmodule